// File: doc/BRIEF.md
# ISA Bus Cycle Sequencer

This block turns a host-side cycle request into correctly timed ISA command strobes. A requester presents the cycle kind (memory or I/O, read or write, or refresh), a 24-bit address and a per-cycle wait count, then holds the request until a one-clock done pulse returns. The sequencer first drives the address and the address latch enable for one ISA clock. It then asserts the matching command for a base width plus the requested wait states. Finally it releases the command, holds one more ISA clock, and signals completion.

The ISA clock is derived inside the block from one of two clock-enable sources. Each source marks one edge of its own clock in the core clock domain. The PCI-rate source is divided by four and the oscillator-rate source by two. A 16-bit cycle can be cut short by the zero-wait-state input, and a low channel-ready input stretches the command phase. A programmable recovery gap separates an I/O cycle from the next I/O cycle. While an external ISA master owns the bus, the block releases its command drivers and starts no cycle.

Top module: `isa_cycle_seq`

## Requirements
- R1: The ISA clock tick occurs once per 4 pulses of `pci_en_i` when `clk_sel_i`=0 and once per 2 pulses of `osc_en_i` when `clk_sel_i`=1. For a CPU-initiated cycle, `ale_o` is high for exactly one ISA clock period.
- R2: The cycle order is address phase (one ISA clock), then command phase, then end phase (one ISA clock). `done_o` is high for one core clock, one ISA clock after the command is released. The command phase of an 8-bit cycle with `iochrdy_i` high lasts (2 + `wait_i`) ISA clocks.
- R3: `smemr_no` is asserted only together with `memr_no`, and only when address bits [23:20] are zero or the cycle is a refresh. `smemw_no` is asserted only together with `memw_no`, and only when address bits [23:20] are zero.
- R4: `ale_o` is low after reset. It stays high for the whole of a refresh cycle, (4 + `wait_i`) ISA clocks in total, and it stays high while `master_i` is high.
- R5: A refresh cycle (`req_ref_i`=1, which overrides `req_io_i` and `req_wr_i`) drives `refresh_no` low and `aen_o` high for the whole cycle. During its command phase it drives `memr_no` and `smemr_no` low.
- R6: When `req_wide_i`=1 and `zws_ni`=0 at the first ISA clock of the command phase, the command phase lasts one ISA clock. `zws_ni` has no effect on an 8-bit cycle.
- R7: While `iochrdy_i` is low, the command phase does not end. It ends at the first ISA tick after the count is exhausted on which `iochrdy_i` is high.
- R8: After an I/O cycle, the next I/O cycle begins its address phase no sooner than (2 + `recov_i`) ISA clocks after the command is released. A following memory cycle waits only the 2-clock minimum.
- R9: While `master_i` is high, `cmd_oe_o` is 0, all command outputs are inactive (high), no cycle starts and `done_o` stays low.
- R10: Command selection: `req_io_i`=0/1 selects memory or I/O, and `req_wr_i`=0/1 selects read or write. Only the selected one of `memr_no`, `memw_no`, `ior_no` and `iow_no` goes low. `bhe_no` is low during the cycle exactly when `req_wide_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pci_en_i | input | 1 | One pulse per PCI-rate clock edge |
| osc_en_i | input | 1 | One pulse per oscillator-rate clock edge |
| clk_sel_i | input | 1 | 0: PCI source divided by 4, 1: oscillator divided by 2 |
| req_valid_i | input | 1 | Cycle request, held until done |
| req_io_i | input | 1 | 1: I/O space, 0: memory space |
| req_wr_i | input | 1 | 1: write, 0: read |
| req_ref_i | input | 1 | 1: refresh cycle |
| req_wide_i | input | 1 | 1: 16-bit cycle |
| req_addr_i | input | 24 | Cycle address |
| wait_i | input | 3 | Extra wait states |
| recov_i | input | 3 | I/O recovery ISA clocks |
| zws_ni | input | 1 | Zero wait state request, active low |
| iochrdy_i | input | 1 | Channel ready, low stretches command |
| master_i | input | 1 | External ISA master owns the bus |
| done_o | output | 1 | Cycle complete pulse |
| isa_clk_o | output | 1 | ISA clock |
| addr_o | output | 24 | Latched cycle address |
| ale_o | output | 1 | Address latch enable |
| aen_o | output | 1 | Address enable (non-CPU cycle) |
| bhe_no | output | 1 | Byte high enable, active low |
| memr_no | output | 1 | Memory read, active low |
| memw_no | output | 1 | Memory write, active low |
| smemr_no | output | 1 | Low-memory read, active low |
| smemw_no | output | 1 | Low-memory write, active low |
| ior_no | output | 1 | I/O read, active low |
| iow_no | output | 1 | I/O write, active low |
| refresh_no | output | 1 | Refresh cycle, active low |
| cmd_oe_o | output | 1 | Command output drive enable |

## Verification
Every result is a whole number of ISA clock periods P, where P is 4 or 2 core clocks. The address strobe is due P clocks wide. The command is due (2 + wait) × P clocks wide, or P under zero-wait. The done pulse is seen P clocks after the command rises, and the I/O recovery gap is (2 + recovery) × P. The bench samples on the falling edge and counts falling edges while a strobe is asserted, so each width or delay is compared as an exact clock count. The sweep covers both clock sources, all four cycle kinds, wait counts 0 to 3 and addresses on both sides of 1 MB. It also covers refresh, zero-wait, ready stretching, recovery gaps and master ownership.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_CMD, ST_END} isa_state_e;
  typedef struct packed {
    logic refr;
    logic io;
    logic wr;
    logic wide;
  } isa_op_t;
endpackage

// File: rtl/isa_clk_div.sv
module isa_clk_div #(
  parameter int PCI_DIV = 4,
  parameter int OSC_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pci_en_i,
  input  logic osc_en_i,
  input  logic sel_i,
  output logic tick_o,
  output logic isa_clk_o
);
  localparam int MAXD = (PCI_DIV > OSC_DIV) ? PCI_DIV : OSC_DIV;
  localparam int CW   = (MAXD > 2) ? $clog2(MAXD) : 1;

  logic [CW-1:0] cnt_q, last, half;
  logic          src_en;

  assign src_en = sel_i ? osc_en_i : pci_en_i;
  assign last   = sel_i ? CW'(OSC_DIV - 1) : CW'(PCI_DIV - 1);
  assign half   = sel_i ? CW'(OSC_DIV / 2) : CW'(PCI_DIV / 2);
  assign tick_o = src_en && (cnt_q >= last);
  assign isa_clk_o = (cnt_q < half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (src_en)  cnt_q <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
  end

  // R1: never two ticks back to back (divide ratio at least 2)
  a_r1_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/isa_io_recovery.sv
module isa_io_recovery #(
  parameter int REC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [REC_W-1:0] val_i,
  output logic             clear_o
);
  logic [REC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign clear_o = (cnt_q == '0);

  a_r8_gap_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && val_i != '0) |=> !clear_o);
endmodule

// File: rtl/isa_cmd_fsm.sv
module isa_cmd_fsm
  import isa_seq_pkg::*;
#(
  parameter int WS_W     = 3,
  parameter int BASE_CMD = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            req_valid_i,
  input  isa_op_t         op_i,
  input  logic [WS_W-1:0] wait_i,
  input  logic            zws_ni,
  input  logic            iochrdy_i,
  input  logic            master_i,
  input  logic            rec_clear_i,
  output isa_state_e      state_o,
  output isa_op_t         op_o,
  output logic            start_o,
  output logic            io_end_o,
  output logic            done_o
);
  localparam int CW = $clog2(BASE_CMD + (1 << WS_W)) + 1;

  isa_state_e      state_q;
  isa_op_t         op_q;
  logic [WS_W-1:0] wait_q;
  logic [CW-1:0]   cnt_q;
  logic            done_q;
  logic            is_io, cmd_exit;

  assign is_io    = op_i.io && !op_i.refr;
  assign start_o  = tick_i && (state_q == ST_IDLE) && req_valid_i && !master_i
                    && (!is_io || rec_clear_i);
  // zero-wait only shortens 16-bit cycles; ready must be high to leave
  assign cmd_exit = iochrdy_i && ((cnt_q == '0) || (op_q.wide && !zws_ni));
  assign io_end_o = tick_i && (state_q == ST_END) && op_q.io && !op_q.refr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      wait_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_o) begin
        state_q <= ST_ADDR;
        op_q    <= op_i;
        wait_q  <= wait_i;
      end else if (tick_i) begin
        unique case (state_q)
          ST_ADDR: begin
            state_q <= ST_CMD;
            cnt_q   <= CW'(BASE_CMD - 1) + CW'(wait_q);
          end
          ST_CMD: begin
            if (cmd_exit)            state_q <= ST_END;
            else if (cnt_q != '0)    cnt_q   <= cnt_q - 1'b1;
          end
          ST_END: begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign op_o    = op_q;
  assign done_o  = done_q;

  a_r2_addr_then_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && tick_i) |=> (state_q == ST_CMD));
  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_hold_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD && !iochrdy_i) |=> (state_q == ST_CMD));
endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_seq_pkg::*;
#(
  parameter int AW       = 24,
  parameter int WS_W     = 3,
  parameter int REC_W    = 3,
  parameter int BASE_CMD = 2,
  parameter int PCI_DIV  = 4,
  parameter int OSC_DIV  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pci_en_i,
  input  logic             osc_en_i,
  input  logic             clk_sel_i,
  input  logic             req_valid_i,
  input  logic             req_io_i,
  input  logic             req_wr_i,
  input  logic             req_ref_i,
  input  logic             req_wide_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [WS_W-1:0]  wait_i,
  input  logic [REC_W-1:0] recov_i,
  input  logic             zws_ni,
  input  logic             iochrdy_i,
  input  logic             master_i,
  output logic             done_o,
  output logic             isa_clk_o,
  output logic [AW-1:0]    addr_o,
  output logic             ale_o,
  output logic             aen_o,
  output logic             bhe_no,
  output logic             memr_no,
  output logic             memw_no,
  output logic             smemr_no,
  output logic             smemw_no,
  output logic             ior_no,
  output logic             iow_no,
  output logic             refresh_no,
  output logic             cmd_oe_o
);
  localparam int MB_BIT = 20;

  logic       tick, start, io_end, rec_clear;
  isa_state_e state;
  isa_op_t    op_in, op_q;
  logic [AW-1:0] addr_q;
  logic busy, ref_cyc, cmd_on, low_mb;

  assign op_in = '{refr: req_ref_i, io: req_io_i, wr: req_wr_i, wide: req_wide_i};

  isa_clk_div #(.PCI_DIV(PCI_DIV), .OSC_DIV(OSC_DIV)) u_div (
    .clk_i, .rst_ni, .pci_en_i, .osc_en_i, .sel_i(clk_sel_i),
    .tick_o(tick), .isa_clk_o
  );

  isa_io_recovery #(.REC_W(REC_W)) u_rec (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(io_end), .val_i(recov_i),
    .clear_o(rec_clear)
  );

  isa_cmd_fsm #(.WS_W(WS_W), .BASE_CMD(BASE_CMD)) u_fsm (
    .clk_i, .rst_ni, .tick_i(tick), .req_valid_i, .op_i(op_in), .wait_i,
    .zws_ni, .iochrdy_i, .master_i, .rec_clear_i(rec_clear),
    .state_o(state), .op_o(op_q), .start_o(start), .io_end_o(io_end), .done_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (start) addr_q <= req_addr_i;
  end

  assign busy    = (state != ST_IDLE);
  assign ref_cyc = busy && op_q.refr;
  assign cmd_on  = (state == ST_CMD) && !master_i;
  assign low_mb  = (addr_q[AW-1:MB_BIT] == '0);

  assign addr_o     = addr_q;
  assign ale_o      = (state == ST_ADDR) || ref_cyc || master_i;
  assign aen_o      = ref_cyc;
  assign refresh_no = !ref_cyc;
  assign bhe_no     = !(busy && op_q.wide && !op_q.refr);
  assign cmd_oe_o   = !master_i;

  assign memr_no  = !(cmd_on && (op_q.refr || (!op_q.io && !op_q.wr)));
  assign memw_no  = !(cmd_on && !op_q.refr && !op_q.io && op_q.wr);
  assign ior_no   = !(cmd_on && !op_q.refr && op_q.io && !op_q.wr);
  assign iow_no   = !(cmd_on && !op_q.refr && op_q.io && op_q.wr);
  assign smemr_no = !(!memr_no && (op_q.refr || low_mb));
  assign smemw_no = !(!memw_no && low_mb);

  a_r3_smemr_with_memr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smemr_no |-> !memr_no);
  a_r3_smemw_with_memw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smemw_no |-> (!memw_no && addr_o[AW-1:MB_BIT] == '0));
  a_r5_refresh_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refresh_no |-> (aen_o && ale_o && ior_no && iow_no && memw_no));
  a_r9_master_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |-> (memr_no && memw_no && ior_no && iow_no && !cmd_oe_o));
  a_r10_one_command: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!memr_no, !memw_no, !ior_no, !iow_no}) <= 1);
endmodule

// File: tb/isa_cycle_seq_test.sv
module isa_cycle_seq_test;
  localparam int BASE = 2;

  logic clk = 0, rst_n = 0;
  logic clk_sel = 0, req_valid = 0, req_io = 0, req_wr = 0, req_ref = 0, req_wide = 0;
  logic [23:0] req_addr = '0;
  logic [2:0]  wait_v = '0, recov = '0;
  logic zws_n = 1, iochrdy = 1, master = 0;
  logic done, isa_clk, ale, aen, bhe_n, memr_n, memw_n, smemr_n, smemw_n;
  logic ior_n, iow_n, refresh_n, cmd_oe;
  logic [23:0] addr;
  int n_tests = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  isa_cycle_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .pci_en_i(1'b1), .osc_en_i(1'b1),
    .clk_sel_i(clk_sel), .req_valid_i(req_valid), .req_io_i(req_io),
    .req_wr_i(req_wr), .req_ref_i(req_ref), .req_wide_i(req_wide),
    .req_addr_i(req_addr), .wait_i(wait_v), .recov_i(recov), .zws_ni(zws_n),
    .iochrdy_i(iochrdy), .master_i(master), .done_o(done), .isa_clk_o(isa_clk),
    .addr_o(addr), .ale_o(ale), .aen_o(aen), .bhe_no(bhe_n), .memr_no(memr_n),
    .memw_no(memw_n), .smemr_no(smemr_n), .smemw_no(smemw_n), .ior_no(ior_n),
    .iow_no(iow_n), .refresh_no(refresh_n), .cmd_oe_o(cmd_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic cmd_low();
    return !memr_n || !memw_n || !ior_n || !iow_n;
  endfunction

  task automatic run_cycle(input bit io, input bit wr, input bit refr, input bit wide,
                           input logic [23:0] a, input int w, input bit zws);
    int p, aw, rs, cw, sm, d, line, bh, exp_w;
    p = clk_sel ? 2 : 4;
    req_io = io; req_wr = wr; req_ref = refr; req_wide = wide;
    req_addr = a; wait_v = 3'(w); zws_n = !zws; req_valid = 1;
    @(negedge clk);
    while (!ale) @(negedge clk);
    aw = 0; rs = 0;
    while (ale) begin
      aw++;
      if (!memr_n && !smemr_n && !refresh_n && aen) rs++;
      @(negedge clk);
    end
    if (refr) begin
      chk("R4 refresh ale width", aw, (2 + BASE + w) * p);
      chk("R5 refresh strobes", rs, (BASE + w) * p);
      chk("R2 refresh done", int'(done), 1);
      req_valid = 0;
      return;
    end
    chk("R1 ale width", aw, p);
    line = {!memr_n, !memw_n, !ior_n, !iow_n};
    bh = bhe_n;
    cw = 0; sm = 0;
    while (cmd_low()) begin
      cw++;
      if (!smemr_n || !smemw_n) sm++;
      @(negedge clk);
    end
    exp_w = (zws && wide) ? p : (BASE + w) * p;
    chk(zws ? "R6 zero-wait width" : "R2 command width", cw, exp_w);
    chk("R10 command line", line, io ? (wr ? 1 : 2) : (wr ? 4 : 8));
    chk("R10 bhe", int'(bh), int'(!wide));
    chk("R3 low-memory strobe", sm, (!io && a[23:20] == 0) ? cw : 0);
    d = 0;
    while (!done) begin d++; @(negedge clk); end
    chk("R2 done delay", d, p);
    req_valid = 0;
  endtask

  task automatic io_gap(input int r, input bit next_io);
    int n;
    clk_sel = 0; recov = 3'(r);
    req_io = 1; req_wr = 1; req_ref = 0; req_wide = 0; wait_v = 0; zws_n = 1;
    req_addr = 24'h0003F8; req_valid = 1;
    @(negedge clk);
    while (!ale) @(negedge clk);
    while (ale) @(negedge clk);
    while (!iow_n) @(negedge clk);
    req_io = next_io;
    n = 0;
    while (!ale) begin n++; @(negedge clk); end
    chk(next_io ? "R8 io recovery gap" : "R8 memory after io gap", n,
        (2 + (next_io ? r : 0)) * 4);
    req_valid = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 ale after reset", int'(ale), 0);
    chk("R2 done after reset", int'(done), 0);
    chk("R10 commands idle after reset", int'({memr_n, memw_n, ior_n, iow_n, refresh_n}), 31);
    chk("R9 drive enabled", int'(cmd_oe), 1);

    for (int s = 0; s < 2; s++) begin
      clk_sel = s[0];
      for (int k = 0; k < 4; k++)
        for (int w = 0; w < 4; w++)
          run_cycle(k[1], k[0], 0, w[0], (w[1] ? 24'h120000 : 24'h00C800) + 24'(k),
                    w, 0);
      for (int w = 0; w < 4; w++) run_cycle(0, 0, 1, 0, 24'h0, w, 0);
    end

    // zero wait: 16-bit shortened, 8-bit unaffected
    clk_sel = 0;
    run_cycle(0, 0, 0, 1, 24'h0A0000, 3, 1);
    run_cycle(0, 1, 0, 1, 24'h200000, 2, 1);
    run_cycle(0, 0, 0, 0, 24'h0A0000, 1, 1);

    // ready stretch (R7)
    begin
      int n;
      req_io = 0; req_wr = 0; req_ref = 0; req_wide = 0; wait_v = 0; zws_n = 1;
      req_addr = 24'h0D0000; iochrdy = 0; req_valid = 1;
      @(negedge clk);
      while (!ale) @(negedge clk);
      while (ale) @(negedge clk);
      n = 0;
      while (!memr_n) begin
        n++;
        if (n == 18) iochrdy = 1;
        @(negedge clk);
      end
      chk("R7 ready stretch width", n, 20);
      req_valid = 0;
      while (!done) @(negedge clk);
      @(negedge clk);
    end

    io_gap(0, 1);
    io_gap(3, 1);
    io_gap(5, 1);
    io_gap(5, 0);
    recov = 0;

    // external master ownership (R9, R4)
    begin
      int dn, cmds;
      master = 1; req_io = 0; req_wr = 1; req_addr = 24'h001000; req_valid = 1;
      dn = 0; cmds = 0;
      repeat (40) begin
        @(negedge clk);
        if (done) dn++;
        if (cmd_low()) cmds++;
      end
      chk("R9 no done under master", dn, 0);
      chk("R9 no command under master", cmds, 0);
      chk("R9 drive released", int'(cmd_oe), 0);
      chk("R4 ale high under master", int'(ale), 1);
      master = 0;
      dn = 0;
      repeat (60) begin
        @(negedge clk);
        if (done) begin dn++; req_valid = 0; end
      end
      chk("R9 cycle after release", dn, 1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_fail++; n_tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule